// File: doc/BRIEF.md
# Peripheral Clock Source Mux and Divider

This block produces one gated peripheral clock. It picks one of four free-running source clocks, divides the chosen clock by a programmable integer from 1 to 256, and passes the result through an output gate. Software reaches it through two 32-bit registers on a simple write/read port in the `clk` domain. The control word holds the source code, the divide field and three flags. The gate word holds one disable bit.

To change settings, software follows a fixed sequence. First it optionally sets the stop flag so the output parks low. It then writes the new source and divide value with the change-enable flag set, and polls the busy flag until it clears. Finally it clears both flags. Inside the block a glitch-free mux hands over between source clocks with a synchronized handshake. A new divide value is loaded only when the divided clock wraps. Busy drops once the divider has taken the value and the mux reports the requested source as live.

Top module: `ckg_periph_clk`

## Requirements
- R1: During reset and once reset has been released and settled, the control word reads 0x0000_0000 (source 0, divide by 1, all flags clear), the gate word reads 0x0000_0200 (output disabled), and `clk_out` stays low.
- R2: With divide field D in control bits 7:0 (0 to 255), the period of `clk_out` is (D+1) periods of the selected source.
- R3: For D of 1 or more, `clk_out` is high for ceil((D+1)/2) source periods and low for the rest. For D = 0 it follows the source, high for half a source period.
- R4: Control bits 31:30 with value n select `src_clk[n]`, where 0 is the main clock, 1 is PLL M, 2 is the video PLL and 3 is the USB PHY clock.
- R5: A control write with bit 29 (change-enable) at 0 leaves the source and divide fields unchanged. Every control write updates bit 29 and bit 27 (stop).
- R6: Bit 28 (busy) is read-only. It reads 1 from the cycle after an accepted field write until the new setting drives the output. A field write made while busy is set is ignored.
- R7: While bit 27 (stop) is 1, `clk_out` is held low. Clearing it lets the output run again.
- R8: Gate word bit 9 at 1 holds `clk_out` low and at 0 enables it. Other gate bits have no effect and read 0.
- R9: No high or low phase of `clk_out` is shorter than half the shortest source period. This holds across source changes, divide changes, stop changes and gate changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | 4 | Candidate source clocks, index = source code |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word read data, busy included |
| gate_we | input | 1 | Gate word write strobe |
| gate_wdata | input | 32 | Gate word write data |
| gate_rdata | output | 32 | Gate word read data |
| clk_out | output | 1 | Divided, gated peripheral clock |

## Verification
The hardest case to reach is a handover while the old divided clock is in a long high phase, or while the output is already enabled. Those are the moments when a runt pulse or a lost edge would appear. The stimulus reaches them with seeded random source and divide changes, many made with the stop flag clear, on four source clocks whose periods do not divide into one another. An edge monitor times every phase of `clk_out` throughout the run. Directed writes made during the busy window and with change-enable clear then show that the fields hold their value.

// File: rtl/ckg_pkg.sv
`timescale 1ns/1ps
package ckg_pkg;
  localparam int NSRC         = 4;
  localparam int SEL_W        = $clog2(NSRC);
  localparam int DIV_W        = 8;
  localparam int REG_W        = 32;
  // control word layout
  localparam int SEL_LSB      = 30;
  localparam int CE_BIT       = 29;
  localparam int BUSY_BIT     = 28;
  localparam int STOP_BIT     = 27;
  localparam int DIV_LSB      = 0;
  // gate word layout
  localparam int GATE_OFF_BIT = 9;

  typedef struct packed {
    logic [SEL_W-1:0] src;
    logic [DIV_W-1:0] div;
  } ckg_setting_t;
endpackage

// File: rtl/ckg_rst_sync.sv
`timescale 1ns/1ps
module ckg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/ckg_ctl_regs.sv
`timescale 1ns/1ps
module ckg_ctl_regs
  import ckg_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [REG_W-1:0]  ctl_wdata,
  output logic [REG_W-1:0]  ctl_rdata,
  input  logic              gate_we,
  input  logic [REG_W-1:0]  gate_wdata,
  output logic [REG_W-1:0]  gate_rdata,
  input  logic              ack_tgl,
  input  logic [NSRC-1:0]   act_sel,
  output ckg_setting_t      setting,
  output logic              req_tgl,
  output logic              stop_req,
  output logic              gate_off
);
  localparam logic [NSRC-1:0] ACT_RST = NSRC'(1);

  ckg_setting_t    set_q, set_n;
  logic            ce_q, ce_n, stop_q, stop_n, req_q, req_n, gate_q, gate_n;
  logic [SYNC-1:0] ack_sh;
  logic [NSRC-1:0] act_sh [SYNC];
  logic            ack_s, busy, accept;
  logic [NSRC-1:0] act_s, act_want;
  logic            unused_bits;

  // synchronizers from the divided and source domains
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_sh <= '0;
      for (int k = 0; k < SYNC; k++) act_sh[k] <= ACT_RST;
    end else begin
      ack_sh    <= {ack_sh[SYNC-2:0], ack_tgl};
      act_sh[0] <= act_sel;
      for (int k = 1; k < SYNC; k++) act_sh[k] <= act_sh[k-1];
    end
  end

  assign ack_s    = ack_sh[SYNC-1];
  assign act_s    = act_sh[SYNC-1];
  assign act_want = NSRC'(1) << set_q.src;
  assign busy     = (req_q != ack_s) || (act_s != act_want);
  assign accept   = ctl_we && ctl_wdata[CE_BIT] && !busy;

  always_comb begin
    set_n  = set_q;
    ce_n   = ce_q;
    stop_n = stop_q;
    req_n  = req_q;
    gate_n = gate_q;
    if (ctl_we) begin
      ce_n   = ctl_wdata[CE_BIT];
      stop_n = ctl_wdata[STOP_BIT];
    end
    if (accept) begin
      set_n.src = ctl_wdata[SEL_LSB +: SEL_W];
      set_n.div = ctl_wdata[DIV_LSB +: DIV_W];
      req_n     = !req_q;
    end
    if (gate_we) gate_n = gate_wdata[GATE_OFF_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q  <= '0;
      ce_q   <= 1'b0;
      stop_q <= 1'b0;
      req_q  <= 1'b0;
      gate_q <= 1'b1;
    end else begin
      set_q  <= set_n;
      ce_q   <= ce_n;
      stop_q <= stop_n;
      req_q  <= req_n;
      gate_q <= gate_n;
    end
  end

  always_comb begin
    ctl_rdata                        = '0;
    ctl_rdata[SEL_LSB +: SEL_W]      = set_q.src;
    ctl_rdata[CE_BIT]                = ce_q;
    ctl_rdata[BUSY_BIT]              = busy;
    ctl_rdata[STOP_BIT]              = stop_q;
    ctl_rdata[DIV_LSB +: DIV_W]      = set_q.div;
    gate_rdata                       = '0;
    gate_rdata[GATE_OFF_BIT]         = gate_q;
  end

  assign setting  = set_q;
  assign req_tgl  = req_q;
  assign stop_req = stop_q;
  assign gate_off = gate_q;
  assign unused_bits = ^{ctl_wdata[BUSY_BIT], ctl_wdata[STOP_BIT-1:DIV_LSB+DIV_W],
                         gate_wdata[REG_W-1:GATE_OFF_BIT+1], gate_wdata[GATE_OFF_BIT-1:0]};

  AST_NO_CE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[CE_BIT]) |=> (set_q == $past(set_q))); // R5
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && busy) |=> (set_q == $past(set_q))); // R6
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R6
endmodule

// File: rtl/ckg_src_mux.sv
`timescale 1ns/1ps
module ckg_src_mux
  import ckg_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic [NSRC-1:0]  src_clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             mux_clk,
  output logic [NSRC-1:0]  act_sel
);
  logic [NSRC-1:0] on_vec;
  logic [NSRC-1:0] gated;

  for (genvar i = 0; i < NSRC; i++) begin : g_leg
    localparam logic            RST_ON = (i == 0);
    localparam logic [NSRC-1:0] OWN    = NSRC'(1) << i;
    logic            leg_rst_n;
    logic [SYNC-1:0] ch_q;
    logic            on_q;
    logic            want;

    ckg_rst_sync #(.STAGES(SYNC)) u_rs (
      .clk(src_clk[i]), .arst_n(rst_n), .srst_n(leg_rst_n));

    // enable only once every other leg has dropped out
    assign want = (sel == SEL_W'(i)) && ((on_vec & ~OWN) == '0);

    always_ff @(posedge src_clk[i] or negedge leg_rst_n) begin
      if (!leg_rst_n) ch_q <= {SYNC{RST_ON}};
      else            ch_q <= {ch_q[SYNC-2:0], want};
    end

    // enable changes only while this source is low
    always_ff @(negedge src_clk[i] or negedge leg_rst_n) begin
      if (!leg_rst_n) on_q <= RST_ON;
      else            on_q <= ch_q[SYNC-1];
    end

    assign on_vec[i] = on_q;
    assign gated[i]  = src_clk[i] & on_q;
  end

  assign mux_clk = |gated;
  assign act_sel = on_vec;

  always_comb begin
    if (rst_n) AST_ONE_SOURCE: assert ($onehot0(on_vec)); // R9
  end
endmodule

// File: rtl/ckg_div_gate.sv
`timescale 1ns/1ps
module ckg_div_gate
  import ckg_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic             mux_clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             req_tgl,
  input  logic             stop_req,
  input  logic             gate_off,
  output logic             ack_tgl,
  output logic             clk_out
);
  localparam logic [2:0] SH_RST = 3'b100; // {gate_off, stop, req}

  logic             drst_n;
  logic [2:0]       sh_q [SYNC];
  logic             req_s, stop_s, gate_s;
  logic [DIV_W-1:0] cnt_q, cnt_n, cur_q, cur_n;
  logic             ack_q, ack_n, hi_q, hi_n;
  logic             at_end, load;
  logic [DIV_W:0]   ratio, hcnt;
  logic             one_q, en_q;

  ckg_rst_sync #(.STAGES(SYNC)) u_rs (.clk(mux_clk), .arst_n(rst_n), .srst_n(drst_n));

  always_ff @(posedge mux_clk or negedge drst_n) begin
    if (!drst_n) begin
      for (int k = 0; k < SYNC; k++) sh_q[k] <= SH_RST;
    end else begin
      sh_q[0] <= {gate_off, stop_req, req_tgl};
      for (int k = 1; k < SYNC; k++) sh_q[k] <= sh_q[k-1];
    end
  end

  assign req_s  = sh_q[SYNC-1][0];
  assign stop_s = sh_q[SYNC-1][1];
  assign gate_s = sh_q[SYNC-1][2];

  always_comb begin
    at_end = (cnt_q == cur_q);
    load   = at_end && (req_s != ack_q);
    cur_n  = load ? div_val : cur_q;
    ack_n  = load ? req_s : ack_q;
    cnt_n  = at_end ? '0 : cnt_q + 1'b1;
    ratio  = {1'b0, cur_n} + 1'b1;
    hcnt   = (cur_n == '0) ? '0 : ((ratio + 1'b1) >> 1);
    hi_n   = ({1'b0, cnt_n} < hcnt);
  end

  always_ff @(posedge mux_clk or negedge drst_n) begin
    if (!drst_n) begin
      cnt_q <= '0;
      cur_q <= '0;
      ack_q <= 1'b0;
      hi_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      cur_q <= cur_n;
      ack_q <= ack_n;
      hi_q  <= hi_n;
    end
  end

  // path choice and enable switch while the source is low
  always_ff @(negedge mux_clk or negedge drst_n) begin
    if (!drst_n) begin
      one_q <= 1'b1;
      en_q  <= 1'b0;
    end else begin
      one_q <= (cur_q == '0);
      en_q  <= !stop_s && !gate_s;
    end
  end

  assign ack_tgl = ack_q;
  assign clk_out = ((mux_clk & one_q) | hi_q) & en_q;

  AST_CNT_BOUND: assert property (@(posedge mux_clk) disable iff (!drst_n)
    cnt_q <= cur_q); // R2
  AST_ACK_AT_WRAP: assert property (@(posedge mux_clk) disable iff (!drst_n)
    (ack_q != $past(ack_q)) |-> (cnt_q == '0)); // R6
  AST_HIGH_FIRST: assert property (@(posedge mux_clk) disable iff (!drst_n)
    ((cnt_q == '0) && (cur_q != '0)) |-> hi_q); // R3
endmodule

// File: rtl/ckg_periph_clk.sv
`timescale 1ns/1ps
module ckg_periph_clk
  import ckg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_clk,
  input  logic              ctl_we,
  input  logic [REG_W-1:0]  ctl_wdata,
  output logic [REG_W-1:0]  ctl_rdata,
  input  logic              gate_we,
  input  logic [REG_W-1:0]  gate_wdata,
  output logic [REG_W-1:0]  gate_rdata,
  output logic              clk_out
);
  logic            reg_rst_n;
  ckg_setting_t    setting;
  logic            req_tgl, ack_tgl, stop_req, gate_off, mux_clk;
  logic [NSRC-1:0] act_sel;

  ckg_rst_sync #(.STAGES(SYNC_STAGES)) u_reg_rs (
    .clk(clk), .arst_n(rst_n), .srst_n(reg_rst_n));

  ckg_ctl_regs #(.SYNC(SYNC_STAGES)) u_regs (
    .clk(clk), .rst_n(reg_rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .gate_we(gate_we), .gate_wdata(gate_wdata), .gate_rdata(gate_rdata),
    .ack_tgl(ack_tgl), .act_sel(act_sel),
    .setting(setting), .req_tgl(req_tgl), .stop_req(stop_req), .gate_off(gate_off));

  ckg_src_mux #(.SYNC(SYNC_STAGES)) u_mux (
    .src_clk(src_clk), .rst_n(rst_n), .sel(setting.src),
    .mux_clk(mux_clk), .act_sel(act_sel));

  ckg_div_gate #(.SYNC(SYNC_STAGES)) u_div (
    .mux_clk(mux_clk), .rst_n(rst_n), .div_val(setting.div),
    .req_tgl(req_tgl), .stop_req(stop_req), .gate_off(gate_off),
    .ack_tgl(ack_tgl), .clk_out(clk_out));
endmodule

// File: tb/tb_ckg_periph_clk.sv
`timescale 1ns/1ps
module tb_ckg_periph_clk;
  logic        clk, rst_n;
  logic        s0, s1, s2, s3;
  logic [3:0]  src_clk;
  logic        ctl_we, gate_we;
  logic [31:0] ctl_wdata, gate_wdata, ctl_rdata, gate_rdata;
  logic        clk_out;

  int  total = 0, bad = 0;
  int  rises = 0, viol = 0;
  real rise_t = 0.0, edge_t = 0.0, per_t = 0.0, hi_t = 0.0;
  bit  mon_on = 0, done = 0;
  int  cur_src = 0, cur_div = 0;

  localparam real MIN_W = 4.0; // half of the 8 ns fastest source

  assign src_clk = {s3, s2, s1, s0};

  ckg_periph_clk dut (
    .clk(clk), .rst_n(rst_n), .src_clk(src_clk),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .gate_we(gate_we), .gate_wdata(gate_wdata), .gate_rdata(gate_rdata),
    .clk_out(clk_out));

  initial begin clk = 0; forever #2.5 clk = ~clk; end
  initial begin s0 = 0; #1.3; forever #5.0 s0 = ~s0; end
  initial begin s1 = 0; #0.7; forever #4.0 s1 = ~s1; end
  initial begin s2 = 0; #2.1; forever #6.0 s2 = ~s2; end
  initial begin s3 = 0; #3.3; forever #7.0 s3 = ~s3; end

  function automatic real src_period(input int s);
    case (s)
      0: return 10.0;
      1: return 8.0;
      2: return 12.0;
      default: return 14.0;
    endcase
  endfunction

  function automatic logic [31:0] word(input int src, input int div, input bit ce, input bit stop);
    logic [31:0] w;
    w = '0;
    w[31:30] = src[1:0];
    w[29]    = ce;
    w[27]    = stop;
    w[7:0]   = div[7:0];
    return w;
  endfunction

  always @(posedge clk_out) begin
    per_t  = $realtime - rise_t;
    rise_t = $realtime;
    rises++;
  end
  always @(negedge clk_out) hi_t = $realtime - rise_t;
  always @(clk_out) begin
    if (mon_on && ($realtime - edge_t) < MIN_W - 0.001) viol++;
    edge_t = $realtime;
  end

  task automatic chk_int(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_real(input string req, input string what, input real act, input real exp);
    total++;
    if (act < exp - 0.01 || act > exp + 0.01) begin
      bad++;
      $display("FAIL %s %s actual=%0.3f expected=%0.3f", req, what, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [31:0] d);
    @(negedge clk); ctl_we = 1; ctl_wdata = d;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic gate_write(input logic [31:0] d);
    @(negedge clk); gate_we = 1; gate_wdata = d;
    @(negedge clk); gate_we = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (ctl_rdata[28]) @(negedge clk);
  endtask

  task automatic measure(input int src, input int div);
    real t, ep, eh;
    t  = src_period(src);
    ep = (div + 1) * t;
    eh = (div == 0) ? t / 2.0 : ((div + 2) / 2) * t;
    repeat (3) @(posedge clk_out);
    @(negedge clk_out);
    #0.1;
    chk_real("R2 R4", $sformatf("period src=%0d div=%0d", src, div), per_t, ep);
    chk_real("R3", $sformatf("high src=%0d div=%0d", src, div), hi_t, eh);
  endtask

  task automatic program_src(input int src, input int div, input bit use_stop);
    ctl_write(word(cur_src, cur_div, 0, use_stop));
    wait_idle();
    ctl_write(word(src, div, 1, use_stop));
    chk_int("R6", "busy after accepted write", ctl_rdata[28], 1);
    ctl_write(word(src ^ 1, div ^ 8'h5a, 1, use_stop)); // while busy: ignored
    wait_idle();
    ctl_write(word(src ^ 2, div ^ 8'h33, 0, 0));         // CE clear: fields kept
    chk_int("R5 R6", "fields after ignored writes", ctl_rdata, word(src, div, 0, 0));
    cur_src = src; cur_div = div;
    measure(src, div);
  endtask

  task automatic quiet_window(input string req, input string what, input bit expect_quiet);
    int r0;
    repeat (40) @(negedge clk);
    r0 = rises;
    #2000;
    if (expect_quiet) begin
      chk_int(req, {what, " rises"}, rises - r0, 0);
      chk_int(req, {what, " level"}, clk_out, 0);
    end else begin
      total++;
      if (rises - r0 < 10) begin
        bad++;
        $display("FAIL %s %s actual=%0d rises expected=>=10", req, what, rises - r0);
      end
    end
  endtask

  initial begin
    #600000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int r0;
    void'($urandom(32'd2024));
    rst_n = 0; ctl_we = 0; gate_we = 0; ctl_wdata = '0; gate_wdata = '0;
    repeat (10) @(negedge clk);
    chk_int("R1", "ctl in reset", ctl_rdata, 0);
    chk_int("R1", "gate in reset", gate_rdata, 32'h200);
    chk_int("R1", "clk_out in reset", clk_out, 0);
    rst_n = 1;
    repeat (40) @(negedge clk);
    r0 = rises;
    chk_int("R1", "ctl settled", ctl_rdata, 0);
    chk_int("R1", "gate settled", gate_rdata, 32'h200);
    #500;
    chk_int("R1", "no output while gated", rises - r0, 0);

    gate_write(32'h0);
    chk_int("R8", "gate open readback", gate_rdata, 0);
    mon_on = 1;
    measure(0, 0);

    // directed corners
    program_src(1, 0, 1);
    program_src(2, 2, 1);
    program_src(3, 255, 1);
    program_src(0, 1, 0);
    program_src(1, 4, 0);

    // seeded random changes, some without stop
    for (int it = 0; it < 10; it++) begin
      int s, d;
      s = $urandom_range(3, 0);
      d = ($urandom_range(1, 0) == 1) ? $urandom_range(7, 0) : $urandom_range(255, 0);
      program_src(s, d, $urandom_range(1, 0) == 1);
    end

    program_src(2, 3, 1);
    // stop flag
    ctl_write(word(cur_src, cur_div, 0, 1));
    quiet_window("R7", "stop set", 1);
    ctl_write(word(cur_src, cur_div, 0, 0));
    quiet_window("R7", "stop cleared", 0);

    // gate bit and neighbours
    gate_write(32'h0000_0200);
    chk_int("R8", "gate closed readback", gate_rdata, 32'h200);
    quiet_window("R8", "gate closed", 1);
    gate_write(32'hffff_fdff);
    chk_int("R8", "other gate bits read zero", gate_rdata, 0);
    quiet_window("R8", "other gate bits", 0);

    // busy is read-only
    ctl_write(32'h1000_0000 | word(cur_src, cur_div, 0, 0));
    chk_int("R6", "busy bit write ignored", ctl_rdata, word(cur_src, cur_div, 0, 0));
    measure(cur_src, cur_div);

    chk_int("R9", "short phases on clk_out", viol, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule